// File: doc/BRIEF.md
# Vector Carry-Less Multiply Unit

This unit multiplies packed vectors element by element over GF(2): bit products are combined with XOR, and no carry passes between bit positions. One 256-bit operand holds the multiplicands. The multiplier for each lane comes from one of two places: the matching element of a second 256-bit operand, or a single scalar broadcast to every lane.

Each lane forms the full double-width polynomial product. The caller chooses whether the lower or the upper element-sized half goes back to the lane. Element width is chosen per request at run time: eight 32-bit lanes or four 64-bit lanes, all on the same datapath. Lane 0 occupies the least significant bits.

Requests enter through a valid/ready handshake. The packed result leaves one cycle later through a second valid/ready handshake. An unsupported width code gives a zeroed result with an error flag.

Top module: `vclmul_unit`

## Requirements
- R1: With `ew_code` = 32 and `take_high` = 0, result lane i (bits 32i+31:32i) equals bits 31:0 of the 64-bit carry-less product of its two 32-bit operands.
- R2: With `ew_code` = 32 and `take_high` = 1, result lane i equals bits 63:32 of that lane's 64-bit carry-less product.
- R3: With `use_scalar` = 0, lane i of `mcand` is multiplied by lane i of `mplier`, where lane 0 is in the least significant bits.
- R4: With `use_scalar` = 1, every lane of `mcand` is multiplied by the same scalar value, and `mplier` has no effect on the result.
- R5: With `ew_code` = 32 and `use_scalar` = 1, only bits 31:0 of `scalar` are used; bits 63:32 have no effect on the result.
- R6: With `ew_code` = 64, the four 64-bit lanes (lane i in bits 64i+63:64i) return bits 63:0 of the 128-bit product when `take_high` = 0, and bits 127:64 when `take_high` = 1.
- R7: A request accepted on a clock edge (`req_valid` and `req_ready` both high) appears on `res_valid`/`res_data` right after that edge. An unconsumed result keeps `res_valid` high and `res_data` unchanged.
- R8: `req_ready` is high exactly when no result is pending, or when the pending result is consumed in the same cycle. Consuming a result and accepting the next request can therefore happen in the same cycle.
- R9: An `ew_code` other than 32 or 64 gives `res_data` of all zeros, with `res_illegal` high alongside the result. A legal code gives `res_illegal` low.
- R10: After reset, `res_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request this cycle |
| mcand | input | 256 | Packed multiplicand vector |
| mplier | input | 256 | Packed multiplier vector (vector-vector mode) |
| scalar | input | 64 | Broadcast multiplier (vector-scalar mode) |
| use_scalar | input | 1 | 1 selects the broadcast scalar as multiplier |
| take_high | input | 1 | 1 returns the upper half of each product |
| ew_code | input | 7 | Element width in bits: 32 or 64 |
| res_valid | output | 1 | Result pending |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 256 | Packed result vector |
| res_illegal | output | 1 | Result came from an unsupported width code |

## Verification
Two events can land on the same edge: the consumer draining the pending result, and the unit taking the next request. The bench sets this up by holding `res_ready` high while it offers a new request in the cycle right after a result appears. It also releases a long stall while a second request is already waiting. In both cases the bench checks that `req_ready` stayed high, that the first result was seen intact, and that the second result arrives on the next edge with lane values that match a bit-serial reference model.

// File: rtl/vclmul_pkg.sv
package vclmul_pkg;

    parameter int VEC_BITS  = 256;
    parameter int SLOT_BITS = 64;

    typedef enum logic [1:0] {
        EW_32  = 2'd0,
        EW_64  = 2'd1,
        EW_BAD = 2'd2
    } ew_e;

    typedef struct packed {
        logic use_scalar;
        logic take_high;
        ew_e  ew;
    } op_ctrl_t;

    function automatic ew_e decode_width(input logic [6:0] code);
        case (code)
            7'd32:   return EW_32;
            7'd64:   return EW_64;
            default: return EW_BAD;
        endcase
    endfunction

endpackage

// File: rtl/vclmul_core.sv
module vclmul_core #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    always_comb begin
        logic [PW-1:0] acc;
        acc = '0;
        for (int j = 0; j < W; j++) begin
            if (b[j]) acc = acc ^ ({{W{1'b0}}, a} << j);
        end
        prod = acc;
    end

    // R1/R6: a zero factor must give a zero product
    always_comb begin
        if (a == '0 || b == '0) begin
            a_r1_zero_factor: assert (prod == '0);
        end
    end

endmodule

// File: rtl/vclmul_slot.sv
module vclmul_slot
    import vclmul_pkg::*;
#(
    parameter int SW = 64
) (
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b,
    input  ew_e           ew,
    input  logic          take_high,
    output logic [SW-1:0] r
);
    localparam int HW = SW / 2;

    logic [2*SW-1:0] wide_p;
    logic [SW-1:0]   narrow_p [2];
    logic [HW-1:0]   narrow_sel [2];

    vclmul_core #(.W(SW)) u_wide (.a(a), .b(b), .prod(wide_p));

    for (genvar k = 0; k < 2; k++) begin : g_narrow
        vclmul_core #(.W(HW)) u_narrow (
            .a    (a[k*HW +: HW]),
            .b    (b[k*HW +: HW]),
            .prod (narrow_p[k])
        );
        assign narrow_sel[k] = take_high ? narrow_p[k][HW +: HW] : narrow_p[k][0 +: HW];
    end

    always_comb begin
        case (ew)
            EW_64:   r = take_high ? wide_p[SW +: SW] : wide_p[0 +: SW];
            EW_32:   r = {narrow_sel[1], narrow_sel[0]};
            default: r = '0;
        endcase
    end

endmodule

// File: rtl/vclmul_unit.sv
module vclmul_unit
    import vclmul_pkg::*;
#(
    parameter int VLEN = VEC_BITS,
    parameter int ELEN = SLOT_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VLEN-1:0] mcand,
    input  logic [VLEN-1:0] mplier,
    input  logic [ELEN-1:0] scalar,
    input  logic            use_scalar,
    input  logic            take_high,
    input  logic [6:0]      ew_code,
    output logic            res_valid,
    input  logic            res_ready,
    output logic [VLEN-1:0] res_data,
    output logic            res_illegal
);
    localparam int SLOTS = VLEN / ELEN;
    localparam int HALF  = ELEN / 2;

    op_ctrl_t        ctrl;
    logic [ELEN-1:0] bcast;
    logic [VLEN-1:0] mult_vec;
    logic [VLEN-1:0] slot_out;
    logic            accept;

    assign ctrl.use_scalar = use_scalar;
    assign ctrl.take_high  = take_high;
    assign ctrl.ew         = decode_width(ew_code);

    assign bcast    = (ctrl.ew == EW_32) ? {2{scalar[HALF-1:0]}} : scalar;
    assign mult_vec = ctrl.use_scalar ? {SLOTS{bcast}} : mplier;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        vclmul_slot #(.SW(ELEN)) u_slot (
            .a         (mcand[s*ELEN +: ELEN]),
            .b         (mult_vec[s*ELEN +: ELEN]),
            .ew        (ctrl.ew),
            .take_high (ctrl.take_high),
            .r         (slot_out[s*ELEN +: ELEN])
        );
    end

    assign req_ready = !res_valid || res_ready;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_data    <= '0;
            res_illegal <= 1'b0;
        end else if (accept) begin
            res_valid   <= 1'b1;
            res_data    <= (ctrl.ew == EW_BAD) ? '0 : slot_out;
            res_illegal <= (ctrl.ew == EW_BAD);
        end else if (res_ready) begin
            res_valid   <= 1'b0;
        end
    end

    a_r7_launch: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> res_valid);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_illegal));

    a_r8_stall: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ready |-> !req_ready);

    a_r9_zeroed: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_illegal |-> res_data == '0);

    a_r8_drain: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_ready && !req_valid |=> !res_valid);

endmodule

// File: tb/vclmul_unit_tb.sv
module vclmul_unit_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [255:0] mcand = '0;
    logic [255:0] mplier = '0;
    logic [63:0]  scalar = '0;
    logic         use_scalar = 1'b0;
    logic         take_high = 1'b0;
    logic [6:0]   ew_code = 7'd32;
    logic         res_valid;
    logic         res_ready = 1'b1;
    logic [255:0] res_data;
    logic         res_illegal;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    vclmul_unit u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .mcand(mcand), .mplier(mplier), .scalar(scalar), .use_scalar(use_scalar),
        .take_high(take_high), .ew_code(ew_code), .res_valid(res_valid),
        .res_ready(res_ready), .res_data(res_data), .res_illegal(res_illegal)
    );

    // entry: {vary_a, vary_b, w64, hi, sc, a_seed, b_seed, s}
    localparam int NV = 10;
    localparam logic [196:0] VECS [NV] = '{
        {1'b0,1'b0,1'b0,1'b0,1'b0, 64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF, 64'h0},
        {1'b0,1'b0,1'b0,1'b1,1'b0, 64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF, 64'h0},
        {1'b0,1'b0,1'b1,1'b0,1'b0, 64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF, 64'h0},
        {1'b0,1'b0,1'b1,1'b1,1'b0, 64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF, 64'h0},
        {1'b0,1'b0,1'b0,1'b1,1'b0, 64'h80000000_80000000, 64'h80000000_00000001, 64'h0},
        {1'b0,1'b0,1'b1,1'b1,1'b0, 64'h80000000_00000000, 64'h80000000_00000000, 64'h0},
        {1'b1,1'b1,1'b0,1'b0,1'b1, 64'h01234567_89ABCDEF, 64'h55AA55AA_0F0F0F0F, 64'hDEADBEEF_CAFEF00D},
        {1'b1,1'b1,1'b1,1'b1,1'b1, 64'h0F1E2D3C_4B5A6978, 64'h13579BDF_2468ACE0, 64'hC3A5_9966_F00F_1248},
        {1'b0,1'b1,1'b1,1'b0,1'b0, 64'h0,                 64'h31415926_53589793, 64'h0},
        {1'b1,1'b1,1'b0,1'b0,1'b0, 64'hA5A5F00F_3C3C1234, 64'h27182818_28459045, 64'h0}
    };

    function automatic logic [255:0] spread(input logic [63:0] seed, input logic vary);
        logic [255:0] v;
        for (int k = 0; k < 4; k++)
            v[k*64 +: 64] = vary ? (seed ^ (64'h9E3779B9_7F4A7C15 * 64'(k + 1))) : seed;
        return v;
    endfunction

    function automatic logic [127:0] clmul_ref(input logic [63:0] a, input logic [63:0] b, input int w);
        logic [127:0] acc = '0;
        for (int bit_i = 0; bit_i < w; bit_i++) begin
            for (int j = 0; j < w; j++) begin
                if (a[bit_i] && b[j]) acc[bit_i + j] = ~acc[bit_i + j];
            end
        end
        return acc;
    endfunction

    function automatic logic [255:0] ref_vec(input logic [255:0] a, input logic [255:0] b,
                                             input logic [63:0] s, input logic sc,
                                             input logic hi, input logic w64);
        logic [255:0] r;
        logic [127:0] p;
        int w = w64 ? 64 : 32;
        for (int i = 0; i < 256 / w; i++) begin
            logic [63:0] ea = '0;
            logic [63:0] eb = '0;
            for (int q = 0; q < w; q++) begin
                ea[q] = a[i*w + q];
                eb[q] = sc ? s[q] : b[i*w + q];
            end
            p = clmul_ref(ea, eb, w);
            for (int q = 0; q < w; q++) r[i*w + q] = hi ? p[w + q] : p[q];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [255:0] a, input logic [255:0] b, input logic [63:0] s,
                         input logic sc, input logic hi, input logic [6:0] ew);
        mcand = a; mplier = b; scalar = s; use_scalar = sc; take_high = hi; ew_code = ew;
        req_valid = 1'b1;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [255:0] a, b, e1, e2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 res_valid after reset", 256'(res_valid), 256'(0));
        check("R10 req_ready after reset", 256'(req_ready), 256'(1));

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [196:0] t = VECS[v];
            string tag;
            a = spread(t[191:128], t[196]);
            b = spread(t[127:64], t[195]);
            tag = $sformatf("%s %s vec%0d", t[194] ? "R6" : (t[193] ? "R2" : "R1"),
                            t[192] ? "R4" : "R3", v);
            drive(a, b, t[63:0], t[192], t[193], t[194] ? 7'd64 : 7'd32);
            @(negedge clk);
            req_valid = 1'b0;
            check({tag, " valid"}, 256'(res_valid), 256'(1));
            check(tag, res_data, ref_vec(a, b, t[63:0], t[192], t[193], t[194]));
            @(negedge clk);
        end

        // R4: mplier has no effect in scalar mode
        a = spread(64'h1122334455667788, 1'b1);
        drive(a, '1, 64'h00000000_8421_0F0F, 1'b1, 1'b0, 7'd64);
        @(negedge clk); req_valid = 1'b0;
        check("R4 mplier ignored", res_data, ref_vec(a, '0, 64'h00000000_8421_0F0F, 1'b1, 1'b0, 1'b1));
        @(negedge clk);

        // R5: upper scalar bits ignored at 32-bit width
        drive(a, '0, 64'hFFFF0000_0000ABCD, 1'b1, 1'b1, 7'd32);
        @(negedge clk); req_valid = 1'b0;
        check("R5 scalar upper ignored", res_data, ref_vec(a, '0, 64'h00000000_0000ABCD, 1'b1, 1'b1, 1'b0));
        @(negedge clk);

        // R9: illegal width
        drive('1, '1, '1, 1'b0, 1'b0, 7'd16);
        @(negedge clk); req_valid = 1'b0;
        check("R9 illegal data zero", res_data, '0);
        check("R9 illegal flag", 256'(res_illegal), 256'(1));
        @(negedge clk);
        drive('1, '1, '0, 1'b0, 1'b0, 7'd64);
        @(negedge clk); req_valid = 1'b0;
        check("R9 flag clear on legal", 256'(res_illegal), 256'(0));
        @(negedge clk);

        // R8: back-to-back, drain and accept in the same cycle
        a = spread(64'hCAFEBABE_12345678, 1'b1);
        b = spread(64'h0BADF00D_87654321, 1'b1);
        e1 = ref_vec(a, b, '0, 1'b0, 1'b0, 1'b0);
        e2 = ref_vec(b, a, '0, 1'b0, 1'b1, 1'b1);
        drive(a, b, '0, 1'b0, 1'b0, 7'd32);
        @(negedge clk);
        check("R8 first result", res_data, e1);
        check("R8 ready while draining", 256'(req_ready), 256'(1));
        drive(b, a, '0, 1'b0, 1'b1, 7'd64);
        @(negedge clk); req_valid = 1'b0;
        check("R8 second result next cycle", res_data, e2);
        check("R8 second valid", 256'(res_valid), 256'(1));
        @(negedge clk);

        // R7: stall holds result, blocks second request
        res_ready = 1'b0;
        drive(a, b, '0, 1'b0, 1'b0, 7'd32);
        @(negedge clk);
        drive(b, a, '0, 1'b0, 1'b1, 7'd64);
        repeat (3) @(negedge clk);
        check("R7 held data", res_data, e1);
        check("R7 held valid", 256'(res_valid), 256'(1));
        check("R8 not ready while stalled", 256'(req_ready), 256'(0));
        res_ready = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        check("R7 queued request after release", res_data, e2);
        @(negedge clk);
        check("R7 drained", 256'(res_valid), 256'(0));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule